// File: doc/BRIEF.md
# Clock Output Gate and Frequency-Select Controller

This block sits between a clock synthesizer and the output pads of a system clock generator. It decides, for each of twenty-two clock outputs, whether the clock from the synthesizer passes through, is held low, or is released to high impedance. It also hands the synthesizer a 5-bit frequency code. That code comes either from strap pins sampled once after power-up, or from a software-written configuration byte whose bits sit at scattered positions.

Three active-low pins can stop clocks. A processor-stop pin halts the processor group. A bus-stop pin halts the eight gated PCI outputs, while a ninth, free-running PCI output keeps going. A power-down pin halts everything. Per-output enable bits in the configuration bytes can silence single outputs. Each request is resynchronised in the domain of the clock it gates, and it takes effect only while that clock is low. As a result no output shows a shortened pulse, and a stopped output always rests low. A global three-state bit releases every output enable and overrides all other controls.

Top module: `clkout_gate_ctl`

## Requirements
- R1: The strap code on `strap_fs` is captured on the first `clk` rising edge after `rst_n` goes high. Later changes on `strap_fs` do not change the captured code.
- R2: When bit 3 of configuration byte 0 (`cfg_regs[3]`) is 0, `freq_code` equals the captured strap code.
- R3: When `cfg_regs[3]` is 1, `freq_code` is {byte0[2], byte0[1], byte0[6], byte0[5], byte0[4]}, with bit 4 of the code on the left.
- R4: When byte 0 bit 0 is 1, every bit of `clk_oe` is 0, whatever the stops, power-down or enables say. When that bit is 0, every bit of `clk_oe` is 1.
- R5: A cleared enable bit holds its output low while `clk_oe` stays 1. Output index to bit (`cfg_regs` flat index): processor 0..2 → 9,10,11. PCI 3..10 → 16..23. Free PCI 11 → 27. AGP 12..14 → 24,25,26. Interrupt 15,16 → 44,45 and 17 → 8. Reference 18,19 → 40,41. USB 20 → 29. Legacy I/O 21 → 28.
- R6: `cpu_stop_n` low stops outputs 0..2 and no others.
- R7: `pci_stop_n` low stops outputs 3..10. Output 11 keeps toggling.
- R8: `pwr_dwn_n` low stops all outputs.
- R9: `sio_sel_48` equals byte 3 bit 6 (`cfg_regs[30]`): 0 selects 24 MHz, 1 selects 48 MHz.
- R10: A change of a gating request shows at an output after two rising edges of that output's source clock and the falling edge that follows. An output is never high while its source clock is low.
- R11: While `rst_n` is low, all gated outputs are low and the strap register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock for strap capture |
| rst_n | input | 1 | Active-low power-up reset, asynchronous |
| strap_fs | input | 5 | Frequency-select strap pins |
| cfg_regs | input | 48 | Configuration bytes 0..5, byte n at bits 8n+7..8n |
| cpu_stop_n | input | 1 | Active-low processor clock stop |
| pci_stop_n | input | 1 | Active-low PCI clock stop (free output exempt) |
| pwr_dwn_n | input | 1 | Active-low power-down |
| src_clk | input | 22 | Ungated source clock per output |
| clk_out | output | 22 | Gated clock per output |
| clk_oe | output | 22 | Output-enable per pad, 0 means high impedance |
| freq_code | output | 5 | Frequency code to the synthesizer |
| sio_sel_48 | output | 1 | Legacy I/O clock rate select |

## Verification
The gating function is tried with several patterns:
- All enabled, which shows every path opens after reset.
- Scattered single-bit disables, which expose a wrong enable bit mapping.
- Processor stop alone, which separates the stop groups.
- Bus stop alone, which separates the free-running PCI output from its stopped neighbours.
- Power-down, with and without three-state, which shows the priority order.

Two distinct software codes check that every scattered select bit lands in its proper place. A strap-pin change after capture checks that the strap code is held. Every pattern is also sampled in the low phase of the clock to confirm that outputs rest low.

// File: rtl/clkout_gate_pkg.sv
package clkout_gate_pkg;
  localparam int NUM_OUT     = 22;
  localparam int CODE_W      = 5;
  localparam int CFG_BYTES   = 6;
  localparam int CFG_W       = CFG_BYTES * 8;
  localparam int SYNC_STAGES = 2;
  localparam int TRI_BIT     = 0;
  localparam int SWSEL_BIT   = 3;
  localparam int SEL48_BIT   = 3 * 8 + 6;
  localparam int FREE_PCI    = 11;

  typedef enum logic [1:0] {
    GRP_PROC = 2'd0,
    GRP_PCI  = 2'd1,
    GRP_OTHER = 2'd2
  } stop_grp_e;

  function automatic stop_grp_e out_group(input int idx);
    if (idx <= 2)                 return GRP_PROC;
    else if (idx <= 10)           return GRP_PCI;
    else                          return GRP_OTHER;
  endfunction

  // flat bit position inside cfg_regs of the enable bit for output idx
  function automatic int en_bit_pos(input int idx);
    int pos;
    if (idx <= 2)                  pos = 9 + idx;
    else if (idx <= 10)            pos = 16 + (idx - 3);
    else if (idx == FREE_PCI)      pos = 27;
    else if (idx <= 14)            pos = 24 + (idx - 12);
    else if (idx <= 16)            pos = 44 + (idx - 15);
    else if (idx == 17)            pos = 8;
    else if (idx <= 19)            pos = 40 + (idx - 18);
    else if (idx == 20)            pos = 29;
    else                           pos = 28;
    return pos;
  endfunction

  // software code gathered from scattered byte-0 positions, MSB first
  function automatic logic [CODE_W-1:0] sw_code(input logic [7:0] b0);
    return {b0[2], b0[1], b0[6], b0[5], b0[4]};
  endfunction
endpackage

// File: rtl/strap_select.sv
module strap_select
  import clkout_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] strap_fs,
  input  logic [7:0]        cfg_b0,
  output logic [CODE_W-1:0] strap_q,
  output logic              strap_done,
  output logic [CODE_W-1:0] freq_code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q    <= '0;
      strap_done <= 1'b0;
    end else if (!strap_done) begin
      strap_q    <= strap_fs;
      strap_done <= 1'b1;
    end
  end

  always_comb begin
    if (cfg_b0[SWSEL_BIT]) freq_code = sw_code(cfg_b0);
    else                   freq_code = strap_q;
  end
endmodule

// File: rtl/gate_request.sv
module gate_request
  import clkout_gate_pkg::*;
(
  input  logic [CFG_W-1:0]   cfg_regs,
  input  logic               cpu_stop_n,
  input  logic               pci_stop_n,
  input  logic               pwr_dwn_n,
  output logic [NUM_OUT-1:0] run_req
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_req
    localparam int        EN_POS = en_bit_pos(i);
    localparam stop_grp_e GRP    = out_group(i);
    logic grp_stop;
    if (GRP == GRP_PROC) begin : g_proc
      assign grp_stop = !cpu_stop_n;
    end else if (GRP == GRP_PCI) begin : g_pci
      assign grp_stop = !pci_stop_n;
    end else begin : g_free
      assign grp_stop = 1'b0;
    end
    assign run_req[i] = cfg_regs[EN_POS] && !grp_stop && pwr_dwn_n;
  end
endmodule

// File: rtl/ckgate_cell.sv
module ckgate_cell #(
  parameter int STAGES = 2
) (
  input  logic src_clk,
  input  logic rst_n,
  input  logic run_req,
  output logic gate_en,
  output logic gated_clk
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], run_req};
  end

  // enable moves only on the falling edge, so it changes while the clock is low
  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) gate_en <= 1'b0;
    else        gate_en <= sync_q[STAGES-1];
  end

  assign gated_clk = src_clk & gate_en;
endmodule

// File: rtl/clkout_gate_ctl.sv
module clkout_gate_ctl
  import clkout_gate_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CODE_W-1:0]  strap_fs,
  input  logic [CFG_W-1:0]   cfg_regs,
  input  logic               cpu_stop_n,
  input  logic               pci_stop_n,
  input  logic               pwr_dwn_n,
  input  logic [NUM_OUT-1:0] src_clk,
  output logic [NUM_OUT-1:0] clk_out,
  output logic [NUM_OUT-1:0] clk_oe,
  output logic [CODE_W-1:0]  freq_code,
  output logic               sio_sel_48
);
  logic [CODE_W-1:0]  strap_q;
  logic               strap_done;
  logic [NUM_OUT-1:0] run_req;
  logic [NUM_OUT-1:0] gate_en;

  strap_select u_strap (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_fs   (strap_fs),
    .cfg_b0     (cfg_regs[7:0]),
    .strap_q    (strap_q),
    .strap_done (strap_done),
    .freq_code  (freq_code)
  );

  gate_request u_req (
    .cfg_regs   (cfg_regs),
    .cpu_stop_n (cpu_stop_n),
    .pci_stop_n (pci_stop_n),
    .pwr_dwn_n  (pwr_dwn_n),
    .run_req    (run_req)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_cell
    ckgate_cell #(.STAGES(SYNC_STAGES)) u_cell (
      .src_clk   (src_clk[i]),
      .rst_n     (rst_n),
      .run_req   (run_req[i]),
      .gate_en   (gate_en[i]),
      .gated_clk (clk_out[i])
    );
  end

  assign clk_oe     = {NUM_OUT{!cfg_regs[TRI_BIT]}};
  assign sio_sel_48 = cfg_regs[SEL48_BIT];
endmodule

// File: rtl/clkout_gate_ctl_chk.sv
module clkout_gate_ctl_chk
  import clkout_gate_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [CFG_W-1:0]   cfg_regs,
  input logic               cpu_stop_n,
  input logic               pci_stop_n,
  input logic               pwr_dwn_n,
  input logic [NUM_OUT-1:0] src_clk,
  input logic [NUM_OUT-1:0] clk_out,
  input logic [NUM_OUT-1:0] clk_oe,
  input logic [CODE_W-1:0]  freq_code,
  input logic [CODE_W-1:0]  strap_q,
  input logic               strap_done,
  input logic [NUM_OUT-1:0] run_req,
  input logic [NUM_OUT-1:0] gate_en
);
  localparam int FREE_EN = en_bit_pos(FREE_PCI);

  p_strap_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strap_done |=> strap_done && $stable(strap_q));

  p_hw_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_done && !cfg_regs[SWSEL_BIT]) |-> freq_code == strap_q);

  p_sw_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_regs[SWSEL_BIT] |-> freq_code == {cfg_regs[2], cfg_regs[1], cfg_regs[6], cfg_regs[5], cfg_regs[4]});

  p_tristate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_regs[TRI_BIT] |-> clk_oe == '0);

  p_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_regs[TRI_BIT] |-> &clk_oe);

  p_cpu_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_stop_n |-> run_req[2:0] == 3'b000);

  p_free_pci_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pci_stop_n && pwr_dwn_n && cfg_regs[FREE_EN]) |-> run_req[FREE_PCI]);

  p_pdown_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_dwn_n |-> run_req == '0);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    p_rest_low_r10: assert property (@(posedge src_clk[i]) disable iff (!rst_n)
      !clk_out[i]);

    p_gate_latency_r10: assert property (@(posedge src_clk[i]) disable iff (!rst_n)
      $past(rst_n, 2) |-> gate_en[i] == $past(run_req[i], 2));
  end
endmodule

bind clkout_gate_ctl clkout_gate_ctl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_regs   (cfg_regs),
  .cpu_stop_n (cpu_stop_n),
  .pci_stop_n (pci_stop_n),
  .pwr_dwn_n  (pwr_dwn_n),
  .src_clk    (src_clk),
  .clk_out    (clk_out),
  .clk_oe     (clk_oe),
  .freq_code  (freq_code),
  .strap_q    (strap_q),
  .strap_done (strap_done),
  .run_req    (run_req),
  .gate_en    (gate_en)
);

// File: tb/clkout_gate_ctl_tb.sv
module clkout_gate_ctl_tb;
  localparam int N = 22;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    strap_fs = 5'b10110;
  logic [47:0]   cfg_regs;
  logic          cpu_stop_n = 1'b1;
  logic          pci_stop_n = 1'b1;
  logic          pwr_dwn_n = 1'b1;
  logic [N-1:0]  clk_out;
  logic [N-1:0]  clk_oe;
  logic [4:0]    freq_code;
  logic          sio_sel_48;

  always #2.5 clk = ~clk;

  clkout_gate_ctl u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_fs   (strap_fs),
    .cfg_regs   (cfg_regs),
    .cpu_stop_n (cpu_stop_n),
    .pci_stop_n (pci_stop_n),
    .pwr_dwn_n  (pwr_dwn_n),
    .src_clk    ({N{clk}}),
    .clk_out    (clk_out),
    .clk_oe     (clk_oe),
    .freq_code  (freq_code),
    .sio_sel_48 (sio_sel_48)
  );

  typedef struct {
    logic [N-1:0] out;
    logic [N-1:0] oe;
    logic [4:0]   code;
    logic         sel;
    string        tag;
  } exp_t;

  exp_t      sb_q[$];
  int        n_tests = 0;
  int        n_fail  = 0;
  bit        all_done = 1'b0;
  logic [4:0] latched_strap;
  int        en_byte[N];
  int        en_bitn[N];

  // enable bit location per output, written as (byte, bit)
  initial begin
    for (int i = 0; i < 3; i++) begin en_byte[i] = 1; en_bitn[i] = i + 1; end
    for (int i = 3; i < 11; i++) begin en_byte[i] = 2; en_bitn[i] = i - 3; end
    en_byte[11] = 3; en_bitn[11] = 3;
    for (int i = 12; i < 15; i++) begin en_byte[i] = 3; en_bitn[i] = i - 12; end
    en_byte[15] = 5; en_bitn[15] = 4;
    en_byte[16] = 5; en_bitn[16] = 5;
    en_byte[17] = 1; en_bitn[17] = 0;
    en_byte[18] = 5; en_bitn[18] = 0;
    en_byte[19] = 5; en_bitn[19] = 1;
    en_byte[20] = 3; en_bitn[20] = 5;
    en_byte[21] = 3; en_bitn[21] = 4;
  end

  function automatic logic [7:0] cbyte(input int b);
    return cfg_regs[b*8 +: 8];
  endfunction

  function automatic exp_t model(input string tag);
    exp_t e;
    logic [7:0] b0;
    b0 = cbyte(0);
    for (int i = 0; i < N; i++) begin
      logic on;
      on = cbyte(en_byte[i])[en_bitn[i]];
      if (i < 3 && !cpu_stop_n) on = 1'b0;
      if (i >= 3 && i < 11 && !pci_stop_n) on = 1'b0;
      if (!pwr_dwn_n) on = 1'b0;
      e.out[i] = on;
    end
    e.oe   = b0[0] ? '0 : '1;
    e.code = b0[3] ? {b0[2], b0[1], b0[6], b0[5], b0[4]} : latched_strap;
    e.sel  = cbyte(3)[6];
    e.tag  = tag;
    return e;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: apply at a low phase, wait for the two syncing edges and the falling edge, push
  task automatic step(input string tag);
    @(negedge clk); #1;
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    sb_q.push_back(model(tag));
    wait (sb_q.size() == 0);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk); #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q[0];
        chk({e.tag, " R10 high-phase outputs"}, 32'(clk_out), 32'(e.out));
        chk({e.tag, " R4 output enables"}, 32'(clk_oe), 32'(e.oe));
        chk({e.tag, " R2/R3 code"}, 32'(freq_code), 32'(e.code));
        chk({e.tag, " R9 rate select"}, 32'(sio_sel_48), 32'(e.sel));
        @(negedge clk); #1;
        chk({e.tag, " R10 low-phase rest"}, 32'(clk_out), 32'd0);
        void'(sb_q.pop_front());
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!all_done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    cfg_regs = '0;
    cfg_regs[15:8]  = 8'h0F;
    cfg_regs[23:16] = 8'hFF;
    cfg_regs[31:24] = 8'h3F;
    cfg_regs[47:40] = 8'h33;
    latched_strap = 5'b10110;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state, clock high
    chk("R11 outputs in reset", 32'(clk_out), 32'd0);
    chk("R11 code in reset", 32'(freq_code), 32'd0);
    @(negedge clk); #1;
    rst_n = 1'b1;
    step("R1 R2 R10 after reset");

    strap_fs = 5'b01001;
    step("R1 strap pins changed");

    cfg_regs[7:0] = 8'h5A;
    step("R3 soft code 01101");
    chk("R3 soft code value", 32'(freq_code), 32'(5'b01101));
    cfg_regs[7:0] = 8'h3C;
    step("R3 soft code 10011");
    cfg_regs[7:0] = 8'h00;
    step("R2 back to strap");

    cfg_regs[18] = 1'b0;
    cfg_regs[41] = 1'b0;
    cfg_regs[8]  = 1'b0;
    cfg_regs[27] = 1'b0;
    step("R5 scattered disables");
    cfg_regs[18] = 1'b1; cfg_regs[41] = 1'b1; cfg_regs[8] = 1'b1; cfg_regs[27] = 1'b1;

    cpu_stop_n = 1'b0;
    step("R6 processor stop");
    cpu_stop_n = 1'b1;

    pci_stop_n = 1'b0;
    step("R7 bus stop, free output runs");
    pci_stop_n = 1'b1;

    pwr_dwn_n = 1'b0;
    step("R8 power down");
    cfg_regs[0] = 1'b1;
    step("R4 three-state over power down");
    pwr_dwn_n = 1'b1;
    step("R4 three-state running");
    cfg_regs[0] = 1'b0;

    cfg_regs[30] = 1'b1;
    step("R9 select 48");
    cfg_regs[30] = 1'b0;
    step("R9 select 24");

    all_done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule